// File: doc/BRIEF.md
# Chip-Select Address Region Decoder

This block turns a 32-bit physical address into a one-hot chip-select vector for eight external memory regions. Each chip select holds one region word. The word has an enable bit, a base in 16 MB units and a 4-bit size mask. The mask picks a region size of 16, 32, 64 or 128 MB. The address is decoded combinationally against the regions that are currently in force. When no region claims the address, a miss flag is raised.

Software writes one chip select's region word through a simple write port. The block checks every new setting. The mask must be one of the four allowed patterns, and the base must be aligned to the region size. A setting that fails either check is not put into force, and a sticky per-chip-select error bit records it. If regions overlap, the lowest-numbered chip select wins.

Top module: `cs_region_decoder`

## Requirements
- R1: After a synchronous reset, chip select 0 is enabled with base 0 and mask 0xF, so it claims 0x00000000–0x00FFFFFF. Chip selects 1–7 are disabled. All error bits read 0.
- R2: The region word has these fields: bits [5:0] are the base, bit 6 is the enable and bits [11:8] are the mask. Masks 0xF, 0xE, 0xC and 0x8 give 16, 32, 64 and 128 MB, starting at base<<24. An enabled, legal chip select matches when (addr[31:24] AND {0xF, mask}) equals the base. Because the base is only 6 bits wide, addresses with bit 31 or bit 30 set never match.
- R3: An enabled setting with any mask other than 0xF, 0xE, 0xC or 0x8 leaves the chip select with no region, and it sets that chip select's error bit.
- R4: An enabled setting whose base[3:0] AND NOT mask is nonzero leaves the chip select with no region, and it sets that chip select's error bit.
- R5: A setting with the enable bit at 0 removes the region and does not set the error bit.
- R6: cs_hit has at most one bit set. When several regions match, the lowest-numbered chip select is the one reported.
- R7: miss is 1 exactly when no chip select matches, and then cs_hit is 0.
- R8: An error bit stays set until reset, even after a later legal write to the same chip select.
- R9: A write takes effect on the decode from the next clock cycle. A word that differs from the stored one replaces the old region completely, and the old region is released. Rewriting the stored word leaves the region unchanged.
- R10: Write-data bits 7 and 31:12 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one region word |
| wr_sel | input | 3 | Chip select being written |
| wr_data | input | 32 | Region word |
| addr | input | 32 | Physical address to decode |
| cs_hit | output | 8 | One-hot chip select, bit i for chip select i |
| miss | output | 1 | No region claims addr |
| cfg_err | output | 8 | Sticky illegal-setting flag per chip select |

## Verification
On every cycle, the assertions check four things. A region in force always has a legal mask and an aligned base. Error bits never drop without reset. cs_hit is one-hot and names the lowest matching chip select. miss agrees with the set of matching slots. The bench scenarios cover the rest: the region bounds for each size, rejection of illegal masks and misaligned bases, release of the old region on a remap, the ignored data bits, and the reset state.

// File: rtl/cs_dec_pkg.sv
package cs_dec_pkg;

    localparam int NUM_CS  = 8;
    localparam int ADDR_W  = 32;
    localparam int BASE_W  = 6;
    localparam int MASK_W  = 4;
    localparam int PAGE_W  = 8;   // address bits above the 16 MB page

    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              valid;
        logic [BASE_W-1:0] base;
    } cs_cfg_t;

    function automatic cs_cfg_t cfg_from_word(input logic [31:0] w);
        cs_cfg_t c;
        c.mask  = w[11:8];
        c.valid = w[6];
        c.base  = w[5:0];
        return c;
    endfunction

    function automatic logic [PAGE_W-1:0] page_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: PAGE_W];
    endfunction

    function automatic logic mask_ok(input logic [MASK_W-1:0] m);
        return (m == 4'hF) || (m == 4'hE) || (m == 4'hC) || (m == 4'h8);
    endfunction

    function automatic logic base_aligned(input logic [BASE_W-1:0] b,
                                          input logic [MASK_W-1:0] m);
        return (b[MASK_W-1:0] & ~m) == '0;
    endfunction

    function automatic logic region_hit(input logic [PAGE_W-1:0] pg,
                                        input logic [BASE_W-1:0] b,
                                        input logic [MASK_W-1:0] m);
        logic [PAGE_W-1:0] full_mask;
        full_mask = {{(PAGE_W-MASK_W){1'b1}}, m};
        return (pg & full_mask) == PAGE_W'(b);
    endfunction

endpackage

// File: rtl/cs_region_slot.sv
module cs_region_slot
    import cs_dec_pkg::*;
#(
    parameter bit RST_ON = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  cs_cfg_t           wr_cfg,
    input  logic [PAGE_W-1:0] page,
    output logic              match,
    output logic              cfg_err
);

    cs_cfg_t           cfg_q;
    logic              act_on;
    logic [BASE_W-1:0] act_base;
    logic [MASK_W-1:0] act_mask;
    logic              err_q;
    logic              wr_legal;

    assign wr_legal = mask_ok(wr_cfg.mask) && base_aligned(wr_cfg.base, wr_cfg.mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q    <= '{mask: 4'hF, valid: RST_ON, base: '0};
            act_on   <= RST_ON;
            act_base <= '0;
            act_mask <= 4'hF;
            err_q    <= 1'b0;
        end else if (wr_en) begin
            cfg_q <= wr_cfg;
            if (wr_cfg != cfg_q) begin
                act_on   <= wr_cfg.valid && wr_legal;
                act_base <= wr_cfg.base;
                act_mask <= wr_cfg.mask;
            end
            if (wr_cfg.valid && !wr_legal)
                err_q <= 1'b1;
        end
    end

    assign match   = act_on && region_hit(page, act_base, act_mask);
    assign cfg_err = err_q;

    // R3 R4
    act_legal_chk: assert property (@(posedge clk) disable iff (rst)
        act_on |-> (mask_ok(act_mask) && base_aligned(act_base, act_mask)));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);

    // R9
    same_word_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_cfg == cfg_q) |=> ($stable(act_on) && $stable(act_base) && $stable(act_mask)));

endmodule

// File: rtl/cs_priority_pick.sv
module cs_priority_pick #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] raw,
    output logic [N-1:0] hit,
    output logic         none
);

    always_comb begin
        hit = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (raw[i]) begin
                hit    = '0;
                hit[i] = 1'b1;
            end
        end
    end

    assign none = (raw == '0);

    // R6
    onehot_hit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit));

    // R6
    lowest_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (hit != '0) |-> (((hit & raw) == hit) && ((raw & (hit - 1'b1)) == '0)));

endmodule

// File: rtl/cs_region_decoder.sv
module cs_region_decoder
    import cs_dec_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [2:0]            wr_sel,
    input  logic [31:0]           wr_data,
    input  logic [ADDR_W-1:0]     addr,
    output logic [NUM_CS-1:0]     cs_hit,
    output logic                  miss,
    output logic [NUM_CS-1:0]     cfg_err
);

    localparam int SEL_W = $clog2(NUM_CS);

    cs_cfg_t           wr_cfg;
    logic [PAGE_W-1:0] page;
    logic [NUM_CS-1:0] slot_match;

    assign wr_cfg = cfg_from_word(wr_data);
    assign page   = page_of(addr);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_slot
        cs_region_slot #(.RST_ON(i == 0)) u_slot (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_en && (wr_sel == SEL_W'(i))),
            .wr_cfg  (wr_cfg),
            .page    (page),
            .match   (slot_match[i]),
            .cfg_err (cfg_err[i])
        );
    end

    cs_priority_pick #(.N(NUM_CS)) u_pick (
        .clk  (clk),
        .rst  (rst),
        .raw  (slot_match),
        .hit  (cs_hit),
        .none (miss)
    );

    // R7
    miss_agree_chk: assert property (@(posedge clk) disable iff (rst)
        miss == ((slot_match == '0) && (cs_hit == '0)));

endmodule

// File: tb/cs_region_decoder_test.sv
module cs_region_decoder_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] addr = '0;
    logic [7:0]  cs_hit;
    logic        miss;
    logic [7:0]  cfg_err;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cs_region_decoder uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .addr(addr), .cs_hit(cs_hit),
        .miss(miss), .cfg_err(cfg_err)
    );

    typedef struct packed {
        logic [2:0]  sel;
        logic [31:0] word;
        logic [31:0] adr;
        logic [7:0]  hit;
        logic        mis;
        logic [7:0]  err;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t TABLE [NV] = '{
        '{3'd1, 32'h00000E42, 32'h03FFFFFF, 8'h02, 1'b0, 8'h00, 4'd2},  // R2 32 MB top
        '{3'd2, 32'h00000C44, 32'h07000010, 8'h04, 1'b0, 8'h00, 4'd2},  // R2 64 MB
        '{3'd3, 32'h00000848, 32'h0F800000, 8'h08, 1'b0, 8'h00, 4'd2},  // R2 128 MB
        '{3'd4, 32'h00000A50, 32'h10000000, 8'h00, 1'b1, 8'h10, 4'd3},  // R3 bad mask
        '{3'd5, 32'h00000E53, 32'h13000000, 8'h00, 1'b1, 8'h30, 4'd4},  // R4 misaligned
        '{3'd6, 32'h00000F20, 32'h20000000, 8'h00, 1'b1, 8'h30, 4'd5},  // R5 disabled
        '{3'd7, 32'h00000F41, 32'h01000000, 8'h80, 1'b0, 8'h30, 4'd6},  // R6 single
        '{3'd6, 32'h00000F41, 32'h01FFFFFF, 8'h40, 1'b0, 8'h30, 4'd6},  // R6 overlap, low wins
        '{3'd3, 32'h00000F4C, 32'h08000000, 8'h00, 1'b1, 8'h30, 4'd9},  // R9 old region freed
        '{3'd3, 32'h00000F4C, 32'h0C000000, 8'h08, 1'b0, 8'h30, 4'd9},  // R9 rewrite same
        '{3'd1, 32'hFFFFFEC2, 32'h02000000, 8'h02, 1'b0, 8'h30, 4'd10}, // R10 ignored bits
        '{3'd4, 32'h00000F50, 32'h10FFFFFF, 8'h10, 1'b0, 8'h30, 4'd8},  // R8 err stays
        '{3'd0, 32'h00000F00, 32'h00800000, 8'h00, 1'b1, 8'h30, 4'd5},  // R5 cs0 off
        '{3'd2, 32'h00000C44, 32'hC4000000, 8'h00, 1'b1, 8'h30, 4'd2}   // R2 high bits
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] s, input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        addr = 32'h00FFFFFF; #1;
        check("R1 hit cs0", 32'(cs_hit), 32'h01);
        check("R1 err", 32'(cfg_err), 32'h00);
        addr = 32'h01000000; #1;
        check("R1 miss above 16MB", 32'(miss), 32'h1);
        // R7 miss means no hit
        check("R7 hit zero on miss", 32'(cs_hit), 32'h00);

        for (int k = 0; k < NV; k++) begin
            do_write(TABLE[k].sel, TABLE[k].word);
            addr = TABLE[k].adr; #1;
            check($sformatf("R%0d hit v%0d", TABLE[k].req, k), 32'(cs_hit), 32'(TABLE[k].hit));
            check($sformatf("R%0d miss v%0d", TABLE[k].req, k), 32'(miss), 32'(TABLE[k].mis));
            check($sformatf("R%0d err v%0d", TABLE[k].req, k), 32'(cfg_err), 32'(TABLE[k].err));
        end

        // R9 write not yet visible before the edge
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd7; wr_data = 32'h00000F42; addr = 32'h02000000; #1;
        check("R9 before edge", 32'(cs_hit), 32'h02);
        @(negedge clk);
        wr_en = 1'b0; addr = 32'h01000000; #1;
        check("R9 cs7 moved", 32'(cs_hit), 32'h40);

        // R1 reset again restores defaults and clears errors
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        addr = 32'h00000000; #1;
        check("R1 reset hit", 32'(cs_hit), 32'h01);
        check("R1 reset err cleared", 32'(cfg_err), 32'h00);
        addr = 32'h10000000; #1;
        check("R1 others off", 32'(miss), 32'h1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule